// File: doc/BRIEF.md
# Interrupt recognition and masking controller

This block sits next to a core's retire stage and decides, at each instruction boundary, whether an external interrupt is taken and which vector goes with it. There are two sources. The first is a level-sensitive maskable request with its own 8-bit vector, gated by the interrupt-enable flag. The second is a nonmaskable input that acts on its rising edge. The core reports each retiring instruction with a strobe and three kind flags: interrupt-return, stack-selector load, and combined selector-and-offset load.

The decision is made in the same cycle as the retire strobe, so the take pulse lines up with the boundary it acts on. A nonmaskable interrupt always carries vector 2 and has priority over a maskable one. Once taken, it marks itself in service and holds off further nonmaskable interrupts until an interrupt-return retires. An edge that arrives in that time is kept as one pending event. A retiring stack-selector load blocks maskable interrupts at the boundary right after it. A combined selector-and-offset load writes both registers in one instruction, so it leaves no such window.

Top module: `intr_gate`

## Requirements
- R1: After a synchronous reset, take_o is 0, vec_o is 0 and nmi_busy_o is 0, and no nonmaskable interrupt is pending.
- R2: In a cycle with ret_valid=1, irq_req=1, ie_flag=1 and ret_ss_load=0, with no nonmaskable interrupt taken in that cycle, take_o=1 and vec_o equals irq_vec. Any value from 0 to 255 is passed through.
- R3: While ie_flag=0 a maskable request is not taken. A request held asserted is taken at the first retire cycle that has ie_flag=1.
- R4: A rising edge on nmi_in makes a nonmaskable interrupt pending from the next cycle. It is taken at the next retire cycle whatever the value of ie_flag, with vec_o=2. A level held high does not raise a second event.
- R5: The cycle after a nonmaskable interrupt is taken, nmi_busy_o=1. While it is 1 no nonmaskable interrupt is taken. It returns to 0 in the cycle after a retire with ret_iret=1.
- R6: Any number of nmi_in rising edges while nmi_busy_o=1 collapse into one pending event. That event is taken at the first retire cycle after the interrupt-return retire, and only once.
- R7: When a nonmaskable interrupt and a maskable request are both allowed in the same retire cycle, the nonmaskable one is taken with vec_o=2.
- R8: take_o is 1 only in cycles with ret_valid=1, and for a single cycle per retire. vec_o is 0 whenever take_o is 0.
- R9: In a retire cycle with ret_ss_load=1, no maskable interrupt is taken, but a nonmaskable one still is. At the next retire cycle without ret_ss_load, maskable interrupts are allowed again.
- R10: A retire with ret_ss_pair=1 opens no shadow, so a maskable interrupt may be taken in that same cycle.
- R11: A reset applied while a nonmaskable interrupt is in service and another is pending clears both. No take follows on later retires until a new edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Maskable interrupt request, level |
| irq_vec | input | 8 | Vector of the maskable request |
| nmi_in | input | 1 | Nonmaskable interrupt input, rising edge |
| ie_flag | input | 1 | Interrupt-enable flag |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_iret | input | 1 | The retiring instruction is an interrupt-return |
| ret_ss_load | input | 1 | The retiring instruction loads the stack selector alone |
| ret_ss_pair | input | 1 | The retiring instruction loads selector and offset together |
| take_o | output | 1 | Take an interrupt at this boundary |
| vec_o | output | 8 | Vector delivered with take_o, 0 otherwise |
| nmi_busy_o | output | 1 | A nonmaskable interrupt is in service |

## Verification
The hardest state to reach from the ports is a nonmaskable interrupt that is both pending and blocked. It needs an edge during service, then the right ordering of the interrupt-return retire against the next retire. The stimulus builds this on purpose: it takes one event, sends several edges while in service, and only then retires the interrupt-return. A reset is also applied in the middle of that state. Around these directed cases, long random runs mix the retire kinds, the enable flag and sparse toggles of nmi_in. Every cycle is compared with a bench model of pending, mask and edge state.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;

    localparam int VEC_W = 8;
    localparam logic [VEC_W-1:0] NMI_VECTOR = 8'd2;

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic valid;
        logic iret;
        logic ss_load;
        logic ss_pair;
    } retire_t;

    typedef struct packed {
        logic take;
        logic is_nmi;
        vec_t vec;
    } grant_t;

    localparam grant_t GRANT_NONE = '{take: 1'b0, is_nmi: 1'b0, vec: '0};

    // Priority pick: nonmaskable first, then the gated maskable request.
    function automatic grant_t pick_grant(input logic nmi_ok,
                                          input logic irq_ok,
                                          input vec_t irq_vector);
        grant_t g;
        g = GRANT_NONE;
        if (nmi_ok) begin
            g.take   = 1'b1;
            g.is_nmi = 1'b1;
            g.vec    = NMI_VECTOR;
        end else if (irq_ok) begin
            g.take   = 1'b1;
            g.vec    = irq_vector;
        end
        return g;
    endfunction

endpackage

// File: rtl/intr_gate_nmi.sv
module intr_gate_nmi (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic nmi_taken,
    input  logic iret_done,
    output logic nmi_pend,
    output logic nmi_busy
);

    logic nmi_prev;
    logic nmi_edge;

    assign nmi_edge = nmi_in & ~nmi_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
            nmi_busy <= 1'b0;
        end else begin
            nmi_prev <= nmi_in;
            // Edges collapse into one pending flag; a take consumes it.
            nmi_pend <= nmi_edge | (nmi_pend & ~nmi_taken);
            if (nmi_taken)
                nmi_busy <= 1'b1;
            else if (iret_done)
                nmi_busy <= 1'b0;
        end
    end

endmodule

// File: rtl/intr_gate_arb.sv
module intr_gate_arb
    import intr_gate_pkg::*;
(
    input  retire_t rt,
    input  logic    irq_req,
    input  vec_t    irq_vec,
    input  logic    ie_flag,
    input  logic    nmi_pend,
    input  logic    nmi_busy,
    output grant_t  grant
);

    logic shadow_blk;
    logic nmi_ok;
    logic irq_ok;

    // A lone selector load shuts the boundary right after it; the paired load does not.
    assign shadow_blk = rt.ss_load & ~rt.ss_pair;
    assign nmi_ok     = rt.valid & nmi_pend & ~nmi_busy;
    assign irq_ok     = rt.valid & irq_req & ie_flag & ~shadow_blk;

    always_comb begin
        grant = pick_grant(nmi_ok, irq_ok, irq_vec);
    end

endmodule

// File: rtl/intr_gate.sv
module intr_gate
    import intr_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             nmi_in,
    input  logic             ie_flag,
    input  logic             ret_valid,
    input  logic             ret_iret,
    input  logic             ret_ss_load,
    input  logic             ret_ss_pair,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             nmi_busy_o
);

    retire_t rt;
    grant_t  grant;
    logic    nmi_pend;
    logic    nmi_busy;
    logic    nmi_grant;

    assign rt = '{valid: ret_valid, iret: ret_iret,
                  ss_load: ret_ss_load, ss_pair: ret_ss_pair};

    intr_gate_arb u_arb (
        .rt       (rt),
        .irq_req  (irq_req),
        .irq_vec  (irq_vec),
        .ie_flag  (ie_flag),
        .nmi_pend (nmi_pend),
        .nmi_busy (nmi_busy),
        .grant    (grant)
    );

    assign nmi_grant = grant.take & grant.is_nmi;

    intr_gate_nmi u_nmi (
        .clk       (clk),
        .rst       (rst),
        .nmi_in    (nmi_in),
        .nmi_taken (nmi_grant),
        .iret_done (rt.valid & rt.iret),
        .nmi_pend  (nmi_pend),
        .nmi_busy  (nmi_busy)
    );

    assign take_o     = grant.take;
    assign vec_o      = grant.vec;
    assign nmi_busy_o = nmi_busy;

endmodule

// File: rtl/intr_gate_chk.sv
module intr_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic       ie_flag,
    input logic       ret_valid,
    input logic       ret_iret,
    input logic       ret_ss_load,
    input logic       take_o,
    input logic [7:0] vec_o,
    input logic       nmi_busy_o,
    input logic       nmi_pend,
    input logic       nmi_grant
);

    assert_take_on_retire_R8: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ret_valid);

    assert_idle_vec_R8: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> vec_o == 8'd0);

    assert_nmi_vector_R4: assert property (@(posedge clk) disable iff (rst)
        nmi_grant |-> (take_o && vec_o == 8'd2));

    assert_nmi_priority_R7: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && nmi_pend && !nmi_busy_o) |-> nmi_grant);

    assert_ie_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (take_o && !ie_flag) |-> nmi_grant);

    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        nmi_busy_o |-> !nmi_grant);

    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (nmi_busy_o && !(ret_valid && ret_iret)) |=> nmi_busy_o);

    assert_busy_set_R5: assert property (@(posedge clk) disable iff (rst)
        nmi_grant |=> nmi_busy_o);

    assert_shadow_R9: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_ss_load && !nmi_grant) |-> !take_o);

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!nmi_busy_o && !nmi_pend));

endmodule

bind intr_gate intr_gate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ie_flag     (ie_flag),
    .ret_valid   (ret_valid),
    .ret_iret    (ret_iret),
    .ret_ss_load (ret_ss_load),
    .take_o      (take_o),
    .vec_o       (vec_o),
    .nmi_busy_o  (nmi_busy_o),
    .nmi_pend    (nmi_pend),
    .nmi_grant   (nmi_grant)
);

// File: tb/sim_intr_gate.sv
`timescale 1ns/1ps
module sim_intr_gate;

    logic       clk = 1'b0;
    logic       rst;
    logic       irq_req, nmi_in, ie_flag;
    logic [7:0] irq_vec;
    logic       ret_valid, ret_iret, ret_ss_load, ret_ss_pair;
    logic       take_o, nmi_busy_o;
    logic [7:0] vec_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    bit m_prev, m_pend, m_busy;

    always #5 clk = ~clk;

    intr_gate u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
        .nmi_in(nmi_in), .ie_flag(ie_flag), .ret_valid(ret_valid),
        .ret_iret(ret_iret), .ret_ss_load(ret_ss_load), .ret_ss_pair(ret_ss_pair),
        .take_o(take_o), .vec_o(vec_o), .nmi_busy_o(nmi_busy_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; irq_req = 0; nmi_in = 0; ie_flag = 0; irq_vec = 0;
        ret_valid = 0; ret_iret = 0; ret_ss_load = 0; ret_ss_pair = 0;
        repeat (2) @(posedge clk);
        m_prev = 0; m_pend = 0; m_busy = 0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(take_o === 1'b0, tag, "take_o", int'(take_o), 0);
        chk(vec_o === 8'd0, tag, "vec_o", int'(vec_o), 0);
        chk(nmi_busy_o === 1'b0, tag, "nmi_busy_o", int'(nmi_busy_o), 0);
        @(posedge clk);
        m_prev = nmi_in;
    endtask

    // One cycle: drive, compare with the model, advance the model at the edge.
    task automatic step(input bit r, input bit it, input bit ss, input bit pr,
                        input bit iq, input bit ie, input logic [7:0] v,
                        input bit nmi, input string tag_in);
        bit e_nmi, e_irq, e_take;
        logic [7:0] e_vec;
        string tag;
        @(negedge clk);
        ret_valid = r; ret_iret = it; ret_ss_load = ss; ret_ss_pair = pr;
        irq_req = iq; ie_flag = ie; irq_vec = v; nmi_in = nmi;
        #1;
        e_nmi  = r && m_pend && !m_busy;
        e_irq  = r && !e_nmi && iq && ie && !ss;
        e_take = e_nmi || e_irq;
        e_vec  = e_nmi ? 8'd2 : (e_irq ? v : 8'd0);
        tag = tag_in;
        if (tag == "") begin
            if (!r) tag = "R8";
            else if (e_nmi) tag = (iq && ie) ? "R7" : "R4";
            else if (iq && ie && ss) tag = "R9";
            else if (iq && ie && pr) tag = "R10";
            else if (iq && !ie) tag = "R3";
            else tag = "R2";
        end
        chk(take_o === e_take, tag, "take_o", int'(take_o), int'(e_take));
        chk(vec_o === e_vec, tag, "vec_o", int'(vec_o), int'(e_vec));
        chk(nmi_busy_o === m_busy, "R5", "nmi_busy_o", int'(nmi_busy_o), int'(m_busy));
        @(posedge clk);
        m_pend = (nmi && !m_prev) || (m_pend && !e_nmi);
        m_busy = e_nmi || (m_busy && !(r && it));
        m_prev = nmi;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset("R1");
        // R1: retire right after reset with no source gives nothing
        step(1,0,0,0, 0,1,8'h00, 0, "R1");
        // R2: several vectors including the extremes
        step(1,0,0,0, 1,1,8'h00, 0, "R2");
        step(1,0,0,0, 1,1,8'hFF, 0, "R2");
        step(1,0,0,0, 1,1,8'h5A, 0, "R2");
        // R8: request without retire is not taken
        step(0,0,0,0, 1,1,8'h33, 0, "R8");
        // R3: masked then enabled
        step(1,0,0,0, 1,0,8'h40, 0, "R3");
        step(1,0,0,0, 1,0,8'h40, 0, "R3");
        step(1,0,0,0, 1,1,8'h40, 0, "R3");
        // R9: selector-load shadow, then open again
        step(1,0,1,0, 1,1,8'h21, 0, "R9");
        step(1,0,0,0, 1,1,8'h21, 0, "R9");
        // R10: paired load leaves no shadow
        step(1,0,0,1, 1,1,8'h22, 0, "R10");
        // R4: edge, taken with ie=0, level held high gives no second event
        step(0,0,0,0, 0,0,8'h00, 1, "R4");
        step(1,0,0,0, 0,0,8'h00, 1, "R4");
        step(1,1,0,0, 0,0,8'h00, 1, "R5");
        step(1,0,0,0, 0,0,8'h00, 1, "R4");
        // R7 and R9: pending NMI wins at a selector-load retire with IRQ open
        step(0,0,0,0, 0,0,8'h00, 0, "R7");
        step(0,0,0,0, 0,0,8'h00, 1, "R7");
        step(1,0,1,0, 1,1,8'h77, 1, "R7");
        // R6: edges while busy collapse into one, delivered after iret
        step(1,0,0,0, 0,1,8'h00, 0, "R6");
        step(1,0,0,0, 0,1,8'h00, 1, "R6");
        step(1,0,0,0, 0,1,8'h00, 0, "R6");
        step(0,0,0,0, 0,1,8'h00, 1, "R6");
        step(1,1,0,0, 0,1,8'h00, 0, "R6");
        step(1,0,0,0, 0,1,8'h00, 0, "R6");
        step(1,1,0,0, 0,1,8'h00, 0, "R6");
        step(1,0,0,0, 0,1,8'h00, 0, "R6");
        // R11: reset with NMI in service and another pending
        step(0,0,0,0, 0,0,8'h00, 0, "R11");
        step(0,0,0,0, 0,0,8'h00, 1, "R11");
        step(1,0,0,0, 0,0,8'h00, 0, "R11");
        step(0,0,0,0, 0,0,8'h00, 1, "R11");
        do_reset("R11");
        step(1,0,0,0, 0,0,8'h00, 0, "R11");
        step(1,1,0,0, 0,0,8'h00, 0, "R11");
        step(1,0,0,0, 0,0,8'h00, 0, "R11");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int kind;
            bit nmi_n;
            kind  = $urandom_range(0, 9);
            nmi_n = ($urandom_range(0, 7) == 0) ? !nmi_in : nmi_in;
            step($urandom_range(0, 9) < 6,
                 kind == 0 || kind == 1,
                 kind == 2 || kind == 3,
                 kind == 4,
                 $urandom_range(0, 1) == 1,
                 $urandom_range(0, 3) != 0,
                 8'($urandom_range(0, 255)),
                 nmi_n, "");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule